// File: doc/BRIEF.md
# GPIO Pin Interrupt Trigger Detector

This block watches one set of 32 general-purpose pins and turns pin activity into a single interrupt line. Each pin carries an interrupt-enable bit and a three-bit trigger mode spread over three sensitivity registers. The block keeps the last sampled value of every pin. When a pin's sampled value changes, the pin is an input, and its enable bit is set, the block compares the old and new values against the pin's mode and, if the condition holds, sets that pin's sticky status bit.

Software configures the block through a simple register write port and clears status by writing ones. The combined interrupt output stays high while any status bit is set. Level modes are checked only when a pin changes. A pin held at its active level therefore raises status once, when it enters that level, and does not raise it again after a clear. Debounce filtering and routing beyond the single line belong to the surrounding logic.

Top module: `gpio_trig_det`

## Requirements
- R1: Each pin's trigger mode is the 3-bit value {sens2[i], sens1[i], sens0[i]} taken at that pin's bit position i, independently of every other pin.
- R2: Mode 000 sets status on a falling change (1 to 0), and mode 001 sets status on a rising change (0 to 1). The opposite edge has no effect in either mode.
- R3: Mode 010 sets status when the pin changes to 0, and mode 011 sets status when the pin changes to 1. Holding the active level after a clear does not set status again.
- R4: Any mode with bit 2 set (1xx) sets status on both rising and falling changes.
- R5: A pin whose enable bit is 0 never sets its status bit.
- R6: A pin whose direction input is 1 (output) never sets its status bit.
- R7: Evaluation happens only when a pin's sampled value differs from its stored value. Writing mode or enable registers, or changing direction, with pins steady, sets no status.
- R8: Status bits are sticky. A write to the clear register clears every status bit whose data bit is 1 and leaves the bits whose data bit is 0 unchanged.
- R9: If a trigger and a clear hit the same status bit in the same cycle, the bit ends set.
- R10: irq is high exactly while at least one status bit is set.
- R11: Reset (rst_n low, asynchronous) clears enable, all sensitivity registers, the stored pin values and status, and drives irq low.
- R12: With cfg_we high, cfg_sel selects the write target: 0 enable, 1 sens0, 2 sens1, 3 sens2, 4 status clear. Values 5 to 7 write nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_in | input | 32 | Current pin levels, sampled every clock |
| pin_dir | input | 32 | Per-pin direction, 1 = output |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 3 | Register write target |
| cfg_wdata | input | 32 | Register write data |
| int_status | output | 32 | Sticky per-pin status |
| irq | output | 1 | Combined interrupt line |

## Verification
A pin change driven before a rising edge is sampled at that edge. The status bit it causes, and irq, appear right after the same edge, so each result is due one edge after its stimulus. A register write also takes effect at the edge where it is sampled, so the bench configures modes in earlier cycles than the pin changes that depend on them. A driver applies each stimulus between edges and queues its expected status and irq after the edge. A monitor pops each entry half a cycle later, away from any edge, and compares.

// File: rtl/gtd_pkg.sv
package gtd_pkg;
  localparam int unsigned PINS  = 32;
  localparam int unsigned SEL_W = 3;

  localparam logic [SEL_W-1:0] SEL_ENABLE = 3'd0;
  localparam logic [SEL_W-1:0] SEL_SENS0  = 3'd1;
  localparam logic [SEL_W-1:0] SEL_SENS1  = 3'd2;
  localparam logic [SEL_W-1:0] SEL_SENS2  = 3'd3;
  localparam logic [SEL_W-1:0] SEL_CLEAR  = 3'd4;

  typedef enum logic [2:0] {
    TRIG_FALL = 3'b000,
    TRIG_RISE = 3'b001,
    TRIG_LOW  = 3'b010,
    TRIG_HIGH = 3'b011
  } trig_mode_e;

  // True when a change from old_v to new_v meets the given mode.
  function automatic logic trig_match(input logic [2:0] mode,
                                      input logic old_v,
                                      input logic new_v);
    logic rise, fall;
    rise = new_v & ~old_v;
    fall = old_v & ~new_v;
    if (mode[2]) return rise | fall;
    case (mode)
      TRIG_FALL: return fall;
      TRIG_RISE: return rise;
      TRIG_LOW:  return fall;
      default:   return rise;
    endcase
  endfunction
endpackage

// File: rtl/gtd_cfg_regs.sv
module gtd_cfg_regs
  import gtd_pkg::*;
#(
  parameter int unsigned W = PINS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [SEL_W-1:0] sel,
  input  logic [W-1:0]     wdata,
  output logic [W-1:0]     en_q,
  output logic [W-1:0]     s0_q,
  output logic [W-1:0]     s1_q,
  output logic [W-1:0]     s2_q,
  output logic [W-1:0]     clr_vec
);
  logic [W-1:0] en_d, s0_d, s1_d, s2_d;
  logic en_ld, s0_ld, s1_ld, s2_ld;

  always_comb begin
    en_ld   = we && (sel == SEL_ENABLE);
    s0_ld   = we && (sel == SEL_SENS0);
    s1_ld   = we && (sel == SEL_SENS1);
    s2_ld   = we && (sel == SEL_SENS2);
    en_d    = en_ld ? wdata : en_q;
    s0_d    = s0_ld ? wdata : s0_q;
    s1_d    = s1_ld ? wdata : s1_q;
    s2_d    = s2_ld ? wdata : s2_q;
    clr_vec = (we && (sel == SEL_CLEAR)) ? wdata : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= '0;
      s0_q <= '0;
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      en_q <= en_d;
      s0_q <= s0_d;
      s1_q <= s1_d;
      s2_q <= s2_d;
    end
  end
endmodule

// File: rtl/gtd_edge_eval.sv
module gtd_edge_eval
  import gtd_pkg::*;
#(
  parameter int unsigned W = PINS
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pin_in,
  input  logic [W-1:0] pin_dir,
  input  logic [W-1:0] en,
  input  logic [W-1:0] s0,
  input  logic [W-1:0] s1,
  input  logic [W-1:0] s2,
  output logic [W-1:0] hit
);
  logic [W-1:0] val_q;
  logic [W-1:0] changed;

  assign changed = pin_in ^ val_q;

  for (genvar i = 0; i < W; i++) begin : g_pin
    logic [2:0] mode;
    logic       cond;
    assign mode = {s2[i], s1[i], s0[i]};
    assign cond = trig_match(mode, val_q[i], pin_in[i]);
    assign hit[i] = changed[i] & en[i] & ~pin_dir[i] & cond;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) val_q <= '0;
    else        val_q <= pin_in;
  end
endmodule

// File: rtl/gtd_status.sv
module gtd_status
  import gtd_pkg::*;
#(
  parameter int unsigned W = PINS
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] hit,
  input  logic [W-1:0] clr,
  output logic [W-1:0] status_q,
  output logic         irq
);
  logic [W-1:0] status_d;
  logic         upd;

  always_comb begin
    upd      = (|hit) | (|clr);
    status_d = (status_q & ~clr) | hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   status_q <= '0;
    else if (upd) status_q <= status_d;
  end

  assign irq = |status_q;

  // R8: a status bit not cleared stays set
  a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status_q & $past(status_q) & ~$past(clr)) ==
              ($past(status_q) & ~$past(clr))));

  // R9: a triggered bit ends set, even under a simultaneous clear
  a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (|hit) |=> ((status_q & $past(hit)) == $past(hit)));

  // R10: irq only rises after a trigger
  a_r10_irq_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> ($past(hit) != '0));
endmodule

// File: rtl/gpio_trig_det.sv
module gpio_trig_det
  import gtd_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] pin_in,
  input  logic [31:0] pin_dir,
  input  logic        cfg_we,
  input  logic [2:0]  cfg_sel,
  input  logic [31:0] cfg_wdata,
  output logic [31:0] int_status,
  output logic        irq
);
  localparam int unsigned W = PINS;

  logic [W-1:0] en_q, s0_q, s1_q, s2_q, clr_vec, hit;

  gtd_cfg_regs #(.W(W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .sel(cfg_sel), .wdata(cfg_wdata),
    .en_q(en_q), .s0_q(s0_q), .s1_q(s1_q), .s2_q(s2_q), .clr_vec(clr_vec)
  );

  gtd_edge_eval #(.W(W)) u_eval (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .pin_dir(pin_dir),
    .en(en_q), .s0(s0_q), .s1(s1_q), .s2(s2_q), .hit(hit)
  );

  gtd_status #(.W(W)) u_stat (
    .clk(clk), .rst_n(rst_n), .hit(hit), .clr(clr_vec),
    .status_q(int_status), .irq(irq)
  );

  // R5: newly set status bits belong to enabled pins
  a_r5_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((int_status & ~$past(int_status) & ~$past(en_q)) == '0));

  // R6: newly set status bits belong to input pins
  a_r6_output_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((int_status & ~$past(int_status) & $past(pin_dir)) == '0));
endmodule

// File: tb/gpio_trig_det_bench.sv
module gpio_trig_det_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] pin_in = '0, pin_dir = '0, cfg_wdata = '0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_sel = '0;
  logic [31:0] int_status;
  logic        irq;

  int checks = 0;
  int failures = 0;

  typedef struct {
    logic [31:0] st;
    logic        irq;
    string       tag;
  } exp_t;
  exp_t sb[$];

  always #5 clk = ~clk;

  gpio_trig_det u_gpio_trig_det (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .pin_dir(pin_dir),
    .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .int_status(int_status), .irq(irq)
  );

  task automatic check(input string tag, input logic [31:0] act_st,
                       input logic act_irq, input logic [31:0] exp_st,
                       input logic exp_irq);
    checks++;
    if (act_st !== exp_st || act_irq !== exp_irq) begin
      failures++;
      $display("FAIL %s: status=%h irq=%b expected status=%h irq=%b",
               tag, act_st, act_irq, exp_st, exp_irq);
    end
  endtask

  // Driver: apply one cycle of stimulus, queue the result due after the edge.
  task automatic step(input logic [31:0] pin, input logic [31:0] dir,
                      input logic we, input logic [2:0] sel,
                      input logic [31:0] d, input logic [31:0] exp_st,
                      input string tag);
    exp_t e;
    @(negedge clk);
    pin_in = pin; pin_dir = dir; cfg_we = we; cfg_sel = sel; cfg_wdata = d;
    @(posedge clk);
    e.st = exp_st; e.irq = (exp_st != 0); e.tag = tag;
    sb.push_back(e);
  endtask

  // Monitor: compare half a cycle after each result is due.
  initial begin
    forever begin
      @(negedge clk);
      if (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        check(e.tag, int_status, irq, e.st, e.irq);
      end
    end
  end

  initial begin
    repeat (2000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst_n = 1'b1;
    #1 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R11 reset state", int_status, irq, 32'h0, 1'b0);
    rst_n = 1'b1;
    // configuration, pins steady at 0
    step(32'h0, 32'h0, 1, 3'd0, 32'h0000_00FF, 32'h0, "R12 enable write");
    step(32'h0, 32'h0, 1, 3'd1, 32'h0000_000A, 32'h0, "R12 sens0 write");
    step(32'h0, 32'h0, 1, 3'd2, 32'h0000_000C, 32'h0, "R7 sens1 write quiet");
    step(32'h0, 32'h0, 1, 3'd3, 32'h0000_0030, 32'h0, "R7 sens2 write quiet");
    // bit1 rise mode, bit3 high mode, bit4 dual: all rise
    step(32'h1A, 32'h0, 0, 3'd0, 32'h0, 32'h1A, "R2 R3 R4 rising set");
    step(32'h1A, 32'h0, 1, 3'd4, 32'h1A, 32'h0, "R8 R10 clear, R3 held high");
    step(32'h00, 32'h0, 0, 3'd0, 32'h0, 32'h10, "R4 dual falls, R2 rise-mode falls quiet");
    step(32'h00, 32'h0, 1, 3'd4, 32'h10, 32'h0, "R8 clear dual");
    step(32'h01, 32'h0, 0, 3'd0, 32'h0, 32'h0, "R2 fall mode ignores rise");
    step(32'h00, 32'h0, 0, 3'd0, 32'h0, 32'h01, "R2 fall mode sets");
    step(32'h04, 32'h0, 1, 3'd4, 32'h0, 32'h01, "R8 zero write keeps, R3 low mode rise quiet");
    step(32'h00, 32'h0, 0, 3'd0, 32'h0, 32'h05, "R3 low mode enters low");
    step(32'h00, 32'h0, 1, 3'd4, 32'h01, 32'h04, "R8 partial clear");
    step(32'h100, 32'h0, 0, 3'd0, 32'h0, 32'h04, "R5 disabled pin rise");
    step(32'h000, 32'h0, 0, 3'd0, 32'h0, 32'h04, "R5 disabled pin fall");
    step(32'h20, 32'h20, 0, 3'd0, 32'h0, 32'h04, "R6 output pin toggle quiet");
    step(32'h20, 32'h00, 0, 3'd0, 32'h0, 32'h04, "R7 direction change quiet");
    step(32'h00, 32'h00, 0, 3'd0, 32'h0, 32'h24, "R4 input dual falls");
    step(32'h00, 32'h00, 1, 3'd2, 32'h0000_00FF, 32'h24, "R7 mode write quiet");
    step(32'h20, 32'h00, 1, 3'd4, 32'h24, 32'h20, "R9 set wins over clear");
    step(32'h20, 32'h00, 1, 3'd5, 32'hFFFF_FFFF, 32'h20, "R12 select 5 ignored");
    step(32'h20, 32'h00, 1, 3'd7, 32'hFFFF_FFFF, 32'h20, "R12 select 7 ignored");
    step(32'h20, 32'h00, 1, 3'd4, 32'h20, 32'h0, "R10 irq drops");
    // bit6 now mode 010 (only sens1 set at bit 6)
    step(32'h60, 32'h00, 0, 3'd0, 32'h0, 32'h0, "R1 bit6 low mode rise quiet");
    step(32'h20, 32'h00, 0, 3'd0, 32'h0, 32'h40, "R1 bit6 low mode sets");
    @(negedge clk);
    cfg_we = 1'b0;
    repeat (2) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule